// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between an on-chip request bus and an external asynchronous static RAM with 19 address bits, an 8-bit data bus and active-low chip-select, write-strobe and output-enable lines. The host offers one word at a time with a valid/ready handshake. The block holds the address and write data in registers, then steps through a fixed sequence of phases: setup, strobe, and then either hold (write) or turnaround (read). It drives the three strobes from registers so the RAM sees clean edges.

Each phase length is a whole number of clock cycles. The number is worked out at elaboration from the RAM's nanosecond limits and the clock period. The limits covered are address-to-data time, output-enable-to-data time, cycle time, write pulse width, select-to-write-end time, data setup before the terminating edge, and output-enable release time. Each limit is rounded up to whole cycles, with a floor of one cycle. The data bus leaves the block as a separate output value, a drive-enable and an input value, so the tristate pad sits outside this block. The block never asserts the drive-enable while the RAM may be driving the bus.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: A clock edge with `rst` high sets `ram_ce_n`, `ram_we_n` and `ram_oe_n` to 1, `ram_dq_oe` to 0, `rsp_valid` to 0 and `req_ready` to 1. This holds even when reset arrives in the middle of an access.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the last phase of that access ends, and is 1 again in the cycle after that.
- R3: With the default timing (5 ns clock), an accepted write runs for four cycles, in this order. First comes one setup cycle with all strobes at 1. Next come two strobe cycles with `ram_ce_n`=0, `ram_we_n`=0 and `ram_oe_n`=1. Last comes one hold cycle with `ram_ce_n`=0 and `ram_we_n`=1. The write ends on the rise of `ram_we_n`.
- R4: During every cycle of a write, `ram_dq_oe` is 1 and `ram_dq_out` equals the accepted write data. During every cycle of an access, `ram_addr` equals the accepted address, whatever the host drives meanwhile.
- R5: With the default timing, an accepted read runs for four cycles, in this order. First comes one setup cycle with all strobes at 1. Next come two strobe cycles with `ram_ce_n`=0, `ram_oe_n`=0 and `ram_we_n`=1. Last comes one turnaround cycle with all strobes at 1. `ram_dq_oe` stays 0 throughout.
- R6: `rsp_valid` is a single-cycle pulse in the turnaround cycle of a read. `rsp_rdata` then holds the value `ram_dq_in` had during the last strobe cycle, not during earlier strobe cycles.
- R7: `ram_dq_oe` is never 1 while `ram_oe_n` is 0. At least one cycle with `ram_oe_n`=1 and `ram_dq_oe`=0 separates the end of a read strobe from any cycle that drives the bus.
- R8: `ram_we_n` is 0 only while `ram_ce_n` is 0, and each write-strobe pulse lasts at least the derived write-strobe cycle count (2 by default).
- R9: A `req_valid` presented while `req_ready` is 0 is ignored. It starts no access and changes neither `ram_addr`, `ram_dq_out` nor the strobe sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller is idle and can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data is available |
| rsp_rdata | output | 8 | Captured read data |
| ram_addr | output | 19 | Address to the RAM |
| ram_ce_n | output | 1 | Chip select, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 8 | Value to drive onto the data bus |
| ram_dq_oe | output | 1 | Drive-enable for the data bus pads |
| ram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
A wrong phase or a wrong timer count shows up as a strobe that is in the wrong state in a specific cycle. The per-cycle reference model in the bench sees this in the same cycle, whether a strobe is one cycle early, late or too short. A latch error shows up as a stale value on `ram_addr` or `ram_dq_out` during an access, or as a bad word in a later read. A capture taken on the wrong strobe cycle returns the deliberately corrupted early-cycle value. A broken read/write turnaround shows up in the first cycle where the drive-enable and the output enable overlap, or where the gap between them is missing.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_TURN
  } phase_e;

  // Nanosecond limit (given in ps) rounded up to whole clocks, never below one.
  function automatic int unsigned ps_to_cyc(int unsigned t_ps, int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // Cycles still owed after 'used' cycles of other phases; floor of one.
  function automatic int unsigned rest_cyc(int unsigned need, int unsigned used);
    return (need > used) ? (need - used) : 1;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_strobe_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned RD_STB    = 2,
  parameter int unsigned WR_STB    = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned TURN_CYC  = 1,
  parameter int unsigned CNT_W     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_wr,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic ready
);

  phase_e           phase_q, phase_d;
  logic             wr_q, wr_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    phase_d  = phase_q;
    wr_d     = wr_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      ST_IDLE: begin
        if (start) begin
          phase_d  = ST_SETUP;
          wr_d     = start_wr;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          phase_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = wr_q ? CNT_W'(WR_STB - 1) : CNT_W'(RD_STB - 1);
        end
      end
      ST_STROBE: begin
        if (tmr_done) begin
          phase_d  = wr_q ? ST_HOLD : ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = wr_q ? CNT_W'(HOLD_CYC - 1) : CNT_W'(TURN_CYC - 1);
        end
      end
      ST_HOLD, ST_TURN: begin
        if (tmr_done) phase_d = ST_IDLE;
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  // Read data is taken on the final clock of the read strobe.
  assign capture = (phase_q == ST_STROBE) && tmr_done && !wr_q;

  // Strobes are decoded from the next phase and registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ST_IDLE;
      wr_q    <= 1'b0;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      ready   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
      ce_n    <= !((phase_d == ST_STROBE) || (phase_d == ST_HOLD));
      we_n    <= !((phase_d == ST_STROBE) && wr_d);
      oe_n    <= !((phase_d == ST_STROBE) && !wr_d);
      dq_oe   <= wr_d && (phase_d inside {ST_SETUP, ST_STROBE, ST_HOLD});
      ready   <= (phase_d == ST_IDLE);
    end
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
    end else if (accept) begin
      ram_addr   <= req_addr;
      ram_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= ram_dq_in;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_PS     = 5000,
  parameter int unsigned T_RC_PS    = 10000,
  parameter int unsigned T_AA_PS    = 10000,
  parameter int unsigned T_DOE_PS   = 4500,
  parameter int unsigned T_HZOE_PS  = 5000,
  parameter int unsigned T_WC_PS    = 10000,
  parameter int unsigned T_PWE_PS   = 7000,
  parameter int unsigned T_SCE_PS   = 7000,
  parameter int unsigned T_SD_PS    = 5000,
  parameter int unsigned T_HD_PS    = 0,
  parameter int unsigned T_SA_PS    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int unsigned SETUP_CYC = ps_to_cyc(T_SA_PS, CLK_PS);
  localparam int unsigned HOLD_CYC  = ps_to_cyc(T_HD_PS, CLK_PS);
  localparam int unsigned TURN_CYC  = ps_to_cyc(T_HZOE_PS, CLK_PS);
  localparam int unsigned RD_STB    = max3(ps_to_cyc(T_AA_PS, CLK_PS),
                                           ps_to_cyc(T_DOE_PS, CLK_PS),
                                           rest_cyc(ps_to_cyc(T_RC_PS, CLK_PS),
                                                    SETUP_CYC + TURN_CYC));
  localparam int unsigned WR_STB    = max3(ps_to_cyc(T_PWE_PS, CLK_PS),
                                           ps_to_cyc(T_SCE_PS, CLK_PS),
                                           max3(rest_cyc(ps_to_cyc(T_SD_PS, CLK_PS), SETUP_CYC),
                                                rest_cyc(ps_to_cyc(T_WC_PS, CLK_PS),
                                                         SETUP_CYC + HOLD_CYC),
                                                1));
  localparam int unsigned MAX_CYC   = max3(RD_STB, WR_STB,
                                           max3(SETUP_CYC, HOLD_CYC, TURN_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  logic accept;
  logic capture;

  assign accept = req_valid && req_ready;

  sram_strobe_seq #(
    .SETUP_CYC (SETUP_CYC),
    .RD_STB    (RD_STB),
    .WR_STB    (WR_STB),
    .HOLD_CYC  (HOLD_CYC),
    .TURN_CYC  (TURN_CYC),
    .CNT_W     (CNT_W)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .start_wr (req_write),
    .capture  (capture),
    .ce_n     (ram_ce_n),
    .we_n     (ram_we_n),
    .oe_n     (ram_oe_n),
    .dq_oe    (ram_dq_oe),
    .ready    (req_ready)
  );

  sram_data_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) path_i (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .ram_dq_in  (ram_dq_in),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WR_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_dq_out,
  input logic              ram_ce_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_oe,
  input logic              rsp_valid
);

  logic [15:0] we_lo_q;

  always_ff @(posedge clk) begin
    if (rst || ram_we_n) we_lo_q <= '0;
    else if (we_lo_q != 16'hFFFF) we_lo_q <= we_lo_q + 16'd1;
  end

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_write_data_first_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> $past(ram_dq_oe));

  p_access_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> ($stable(ram_addr) && $stable(ram_dq_out)));

  p_read_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> (!ram_ce_n && ram_we_n));

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(!ram_oe_n) && ram_oe_n));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    !(ram_dq_oe && !ram_oe_n));

  p_turn_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_oe_n) |=> !ram_dq_oe);

  p_we_inside_ce_r8: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_ce_n);

  p_we_width_r8: assert property (@(posedge clk) disable iff (rst)
    (ram_we_n && !$past(ram_we_n) && !$past(rst)) |-> (we_lo_q >= 16'(WR_CYC)));

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WR_CYC (WR_STB)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ram_addr   (ram_addr),
  .ram_dq_out (ram_dq_out),
  .ram_ce_n   (ram_ce_n),
  .ram_we_n   (ram_we_n),
  .ram_oe_n   (ram_oe_n),
  .ram_dq_oe  (ram_dq_oe),
  .rsp_valid  (rsp_valid)
);

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb_top;

  // Expected phase lengths from the RAM limits and a 5 ns clock, rounded up.
  localparam int CLK_PS = 5000;
  localparam int EXP_RD = (10000 + CLK_PS - 1) / CLK_PS; // address-to-data dominates
  localparam int EXP_WR = (7000 + CLK_PS - 1) / CLK_PS;  // write pulse width dominates

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_oe_n;
  logic [7:0]  ram_dq_out;
  logic        ram_dq_oe;
  logic [7:0]  ram_dq_in = 8'h5A;

  always #2.5 clk = ~clk;

  sram_strobe_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  typedef struct {
    bit ce_n, we_n, oe_n, dq_oe, ready, rv;
    bit chk_addr; logic [18:0] addr;
    bit chk_wd;   logic [7:0]  wd;
    logic [7:0] rd;
    string tag;
  } exp_t;

  typedef struct { bit wr; logic [18:0] a; logic [7:0] d; bit junk; } op_t;

  exp_t exp_q[$];
  op_t  ops[$];
  logic [7:0] shadow[int];  // what the bench wrote
  logic [7:0] ram_mem[int]; // behavioural RAM fed by the design's strobes
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rd_run = 0;
  bit cur_junk = 0;

  function automatic exp_t idle_item();
    exp_t e;
    e.ce_n = 1; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0; e.ready = 1; e.rv = 0;
    e.chk_addr = 0; e.addr = '0; e.chk_wd = 0; e.wd = '0; e.rd = '0;
    e.tag = "R2";
    return e;
  endfunction

  task automatic push_op(op_t o);
    exp_t e;
    int n;
    logic [7:0] rv;
    n = o.wr ? EXP_WR : EXP_RD;
    e = idle_item();
    e.ready = 0; e.chk_addr = 1; e.addr = o.a;
    e.tag = o.junk ? (o.wr ? "R3 R4 R9" : "R5 R9") : (o.wr ? "R3 R4" : "R5");
    if (o.wr) begin
      e.chk_wd = 1; e.wd = o.d; e.dq_oe = 1;
      exp_q.push_back(e);                         // setup
      e.ce_n = 0; e.we_n = 0;
      for (int i = 0; i < n; i++) exp_q.push_back(e); // strobe
      e.we_n = 1;
      exp_q.push_back(e);                         // hold
      shadow[o.a] = o.d;
    end else begin
      exp_q.push_back(e);                         // setup
      e.ce_n = 0; e.oe_n = 0;
      for (int i = 0; i < n; i++) exp_q.push_back(e); // strobe
      rv = shadow.exists(o.a) ? shadow[o.a] : 8'h00;
      e.ce_n = 1; e.oe_n = 1; e.rv = 1; e.rd = rv;
      e.tag = o.junk ? "R5 R6 R9" : "R5 R6";
      exp_q.push_back(e);                         // turnaround with response
    end
  endtask

  task automatic check_item(exp_t e);
    bit bad;
    checks++;
    bad = (ram_ce_n !== e.ce_n) || (ram_we_n !== e.we_n) || (ram_oe_n !== e.oe_n) ||
          (ram_dq_oe !== e.dq_oe) || (req_ready !== e.ready) || (rsp_valid !== e.rv);
    if (bad) begin
      fails++;
      $display("FAIL %s cyc %0d: ce/we/oe/oe_drv/rdy/rv got %b%b%b%b%b%b exp %b%b%b%b%b%b",
               e.tag, cyc, ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, req_ready, rsp_valid,
               e.ce_n, e.we_n, e.oe_n, e.dq_oe, e.ready, e.rv);
    end
    if (e.chk_addr && ram_addr !== e.addr) begin
      fails++;
      $display("FAIL %s cyc %0d: ram_addr got %h exp %h", e.tag, cyc, ram_addr, e.addr);
    end
    if (e.chk_wd && ram_dq_out !== e.wd) begin
      fails++;
      $display("FAIL %s cyc %0d: ram_dq_out got %h exp %h", e.tag, cyc, ram_dq_out, e.wd);
    end
    if (e.rv && rsp_rdata !== e.rd) begin
      fails++;
      $display("FAIL %s cyc %0d: rsp_rdata got %h exp %h", e.tag, cyc, rsp_rdata, e.rd);
    end
  endtask

  task automatic check_invariants();
    checks++;
    if (!ram_oe_n && ram_dq_oe) begin
      fails++;
      $display("FAIL R7 cyc %0d: drive %b with oe_n %b, exp no overlap", cyc, ram_dq_oe, ram_oe_n);
    end
    checks++;
    if (!ram_we_n && ram_ce_n) begin
      fails++;
      $display("FAIL R8 cyc %0d: we_n %b with ce_n %b, exp ce_n 0", cyc, ram_we_n, ram_ce_n);
    end
  endtask

  task automatic ram_model();
    if (!ram_ce_n && !ram_we_n && ram_dq_oe) ram_mem[ram_addr] = ram_dq_out;
    if (!ram_ce_n && !ram_oe_n) begin
      logic [7:0] v;
      rd_run++;
      v = ram_mem.exists(ram_addr) ? ram_mem[ram_addr] : 8'h00;
      // Early strobe cycles return corrupted data; only the last one is true (R6).
      ram_dq_in = (rd_run < EXP_RD) ? ~v : v;
    end else begin
      rd_run = 0;
      ram_dq_in = 8'h5A;
    end
  endtask

  task automatic step();
    exp_t e;
    cyc++;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_item();
    check_item(e);
    check_invariants();
    ram_model();
    if (req_ready && exp_q.size() == 0 && ops.size() > 0) begin
      op_t o;
      o = ops.pop_front();
      req_valid = 1; req_write = o.wr; req_addr = o.a; req_wdata = o.d;
      cur_junk = o.junk;
      push_op(o);
    end else if (!req_ready && cur_junk) begin
      // R9: junk offered while busy must be ignored.
      req_valid = 1; req_write = ~req_write;
      req_addr = 19'h2AAAA ^ 19'(cyc); req_wdata = 8'hEE;
    end else begin
      req_valid = 0;
    end
  endtask

  task automatic run_script();
    while (ops.size() > 0 || exp_q.size() > 0) begin
      @(negedge clk);
      step();
    end
    repeat (2) begin
      @(negedge clk);
      step();
    end
  endtask

  task automatic add_op(bit wr, logic [18:0] a, logic [7:0] d, bit junk);
    op_t o;
    o.wr = wr; o.a = a; o.d = d; o.junk = junk;
    ops.push_back(o);
  endtask

  task automatic chk_idle(string tag);
    checks++;
    if (ram_ce_n !== 1 || ram_we_n !== 1 || ram_oe_n !== 1 || ram_dq_oe !== 0 ||
        rsp_valid !== 0 || req_ready !== 1) begin
      fails++;
      $display("FAIL %s cyc %0d: ce/we/oe/drv/rv/rdy got %b%b%b%b%b%b exp 111001",
               tag, cyc, ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid, req_ready);
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) begin
      @(negedge clk);
      chk_idle("R1");
    end
    rst = 0;

    add_op(1, 19'h00000, 8'h3C, 0);
    add_op(1, 19'h7FFFF, 8'hA5, 1);
    add_op(0, 19'h7FFFF, 8'h00, 1);
    add_op(0, 19'h00000, 8'h00, 0);
    add_op(1, 19'h12345, 8'hFF, 0); // write then read back-to-back
    add_op(0, 19'h12345, 8'h00, 0);
    add_op(0, 19'h55555, 8'h00, 0); // never written
    add_op(1, 19'h00001, 8'h81, 0); // read then write back-to-back (R7 gap)
    add_op(0, 19'h00001, 8'h00, 1);
    add_op(1, 19'h12345, 8'h00, 0);
    add_op(0, 19'h12345, 8'h00, 0);
    run_script();

    // Reset in the middle of a write strobe (R1).
    @(negedge clk);
    cyc++;
    req_valid = 1; req_write = 1; req_addr = 19'h00002; req_wdata = 8'h77;
    @(negedge clk);
    cyc++;
    req_valid = 0;
    @(negedge clk);
    cyc++;
    checks++;
    if (ram_we_n !== 0 || ram_ce_n !== 0) begin
      fails++;
      $display("FAIL R3 cyc %0d: we_n/ce_n got %b%b exp 00", cyc, ram_we_n, ram_ce_n);
    end
    rst = 1;
    repeat (2) begin
      @(negedge clk);
      cyc++;
      chk_idle("R1");
    end
    rst = 0;
    @(negedge clk);
    cyc++;
    chk_idle("R1");

    // Recovery after reset.
    add_op(0, 19'h00001, 8'h00, 0);
    add_op(0, 19'h7FFFF, 8'h00, 0);
    run_script();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule